// File: doc/BRIEF.md
# Nibble Block Mover

This block copies a run of 4-bit nibbles from one place to another in a nibble-addressed memory. The host supplies a source pointer, a destination pointer and a length. The host also picks one of two directions. In ascending mode the block walks from the low ends of both regions upward. In descending mode it starts just below both pointers and walks downward. Choosing the right direction makes an overlapping copy come out correct.

The copy is broken into chunks of at most `CHUNK` nibbles. Each chunk is first read completely into a small internal buffer and then written out. The memory port carries one nibble per cycle. A read returns its data one cycle after the request. The block keeps both pointers up to date throughout the copy, and all pointer arithmetic wraps at the address width. When the copy ends, the block raises a one-cycle completion pulse. The surrounding processor uses that pulse to clear its pointer-select register P and its carry flag.

Top module: `nib_block_mover`

## Requirements
- R1: A length of zero makes no memory request; `done_o` rises exactly 2 cycles after the start edge and both pointers keep their loaded values.
- R2: Each chunk moves min(`CHUNK`, remaining) nibbles, so the first burst of reads before any write is min(`CHUNK`, length) long, and the total number of reads and the total number of writes each equal the length.
- R3: With `dir_up_i`=0, each chunk is read from addresses src, src+1, … and written to dst, dst+1, …; after the chunk both pointers advance by the chunk size, so the final pointers are src+length and dst+length.
- R4: With `dir_up_i`=1, both pointers first drop by the chunk size; the chunk is then read from the new src upward and written to the new dst upward; the final pointers are src−length and dst−length.
- R5: All address and pointer arithmetic is taken modulo 2^`ADDR_W`.
- R6: A whole chunk is read before any nibble of it is written, so the final memory image equals a chunk-by-chunk buffered copy, including for overlapping regions.
- R7: One nibble moves per request cycle and read data returns one cycle after the read. A chunk of n nibbles therefore takes 2n+2 cycles, and `done_o` rises 2 + Σ(2n+2) cycles after the start edge.
- R8: `busy_o` is high from the cycle after the start edge through the `done_o` cycle. `done_o` is a single-cycle pulse and is the signal to clear P and carry. `busy_o` is low after it.
- R9: `start_i` while `busy_o` is high is ignored: the copy in progress finishes with its own pointers, length and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled only while idle |
| dir_up_i | input | 1 | 0 = ascending copy, 1 = descending copy with pre-decrement |
| src_i | input | ADDR_W | Initial source pointer |
| dst_i | input | ADDR_W | Initial destination pointer |
| len_i | input | LEN_W | Number of nibbles to move |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle completion pulse (clear P and carry) |
| src_o | output | ADDR_W | Current source pointer |
| dst_o | output | ADDR_W | Current destination pointer |
| mem_req_o | output | 1 | Memory request this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Nibble address |
| mem_wdata_o | output | NIB_W | Write data |
| mem_rdata_i | input | NIB_W | Read data, valid with mem_rvalid_i |
| mem_rvalid_i | input | 1 | Read data valid, one cycle after a read request |

## Verification
The bench builds the mover with `ADDR_W`=6, `LEN_W`=6 and `CHUNK`=4, which gives a 64-nibble memory. With that size, the bench can compare the whole memory image after every run. It sweeps both directions and lengths from 0 through several chunk boundaries, up to the full 63. It also uses source and destination pairs that overlap in both senses and pairs that straddle the address wrap. For every run it computes the final image, the final pointers, the read and write counts, and the completion cycle arithmetically. In some runs it sends a second start request while the block is busy.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC,
    ST_RD,
    ST_WAIT,
    ST_WR,
    ST_FIN
  } nbm_state_e;
endpackage

// File: rtl/nbm_chunk_sel.sv
module nbm_chunk_sel #(
  parameter int LEN_W = 20,
  parameter int CHUNK = 16,
  parameter int CNT_W = $clog2(CHUNK + 1)
) (
  input  logic [LEN_W-1:0] rem_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    if (rem_i >= LEN_W'(CHUNK)) cnt_o = CNT_W'(CHUNK);
    else                        cnt_o = rem_i[CNT_W-1:0];
  end
endmodule

// File: rtl/nbm_ptr_pair.sv
module nbm_ptr_pair #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] src_ld_i,
  input  logic [ADDR_W-1:0] dst_ld_i,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic [CNT_W-1:0]  amt_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o
);
  localparam int PAD = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] ld_val [2];
  logic [ADDR_W-1:0] ptr_q  [2];

  assign step      = {{PAD{1'b0}}, amt_i};
  assign ld_val[0] = src_ld_i;
  assign ld_val[1] = dst_ld_i;

  for (genvar g = 0; g < 2; g++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ptr_q[g] <= '0;
      else if (load_i) ptr_q[g] <= ld_val[g];
      else if (inc_i)  ptr_q[g] <= ptr_q[g] + step;  // wraps at 2^ADDR_W
      else if (dec_i)  ptr_q[g] <= ptr_q[g] - step;
    end
  end

  assign src_o = ptr_q[0];
  assign dst_o = ptr_q[1];

  AST_NO_DOUBLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_i && dec_i)) else $error("inc and dec together");  // R3
endmodule

// File: rtl/nbm_chunk_buf.sv
module nbm_chunk_buf #(
  parameter int NIB_W = 4,
  parameter int CHUNK = 16,
  parameter int IDX_W = $clog2(CHUNK)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [NIB_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [NIB_W-1:0] rdata_o
);
  logic [NIB_W-1:0] buf_q [CHUNK];

  always_ff @(posedge clk_i) begin
    if (we_i) buf_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = buf_q[raddr_i];
endmodule

// File: rtl/nib_block_mover.sv
module nib_block_mover #(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 20,
  parameter int NIB_W  = 4,
  parameter int CHUNK  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_up_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [NIB_W-1:0]  mem_wdata_o,
  input  logic [NIB_W-1:0]  mem_rdata_i,
  input  logic              mem_rvalid_i
);
  import nbm_pkg::*;

  localparam int CNT_W = $clog2(CHUNK + 1);
  localparam int IDX_W = $clog2(CHUNK);
  localparam int PAD   = ADDR_W - CNT_W;

  nbm_state_e       state_q;
  logic [LEN_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q, cnt_c, idx_q, rcv_q;
  logic             up_q;
  logic             last_c, ptr_inc, ptr_dec, chunk_go;
  logic [CNT_W-1:0] ptr_amt;

  nbm_chunk_sel #(.LEN_W(LEN_W), .CHUNK(CHUNK), .CNT_W(CNT_W)) u_sel (
    .rem_i (rem_q),
    .cnt_o (cnt_c)
  );

  assign last_c   = (idx_q == cnt_q - CNT_W'(1));
  assign chunk_go = (state_q == ST_CALC) && (rem_q != '0);
  assign ptr_dec  = chunk_go && up_q;                              // pre-decrement
  assign ptr_inc  = (state_q == ST_WR) && last_c && !up_q;         // post-increment
  assign ptr_amt  = ptr_dec ? cnt_c : cnt_q;

  nbm_ptr_pair #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   ((state_q == ST_IDLE) && start_i),
    .src_ld_i (src_i),
    .dst_ld_i (dst_i),
    .inc_i    (ptr_inc),
    .dec_i    (ptr_dec),
    .amt_i    (ptr_amt),
    .src_o    (src_o),
    .dst_o    (dst_o)
  );

  nbm_chunk_buf #(.NIB_W(NIB_W), .CHUNK(CHUNK), .IDX_W(IDX_W)) u_buf (
    .clk_i   (clk_i),
    .we_i    (mem_rvalid_i),
    .waddr_i (rcv_q[IDX_W-1:0]),
    .wdata_i (mem_rdata_i),
    .raddr_i (idx_q[IDX_W-1:0]),
    .rdata_o (mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      up_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          rem_q   <= len_i;
          up_q    <= dir_up_i;
          state_q <= ST_CALC;
        end
        ST_CALC: begin
          idx_q <= '0;
          if (rem_q == '0) state_q <= ST_FIN;
          else begin
            cnt_q   <= cnt_c;
            state_q <= ST_RD;
          end
        end
        ST_RD: begin
          idx_q <= idx_q + CNT_W'(1);
          if (last_c) begin
            idx_q   <= '0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: state_q <= ST_WR;  // last read data lands here
        ST_WR: begin
          idx_q <= idx_q + CNT_W'(1);
          if (last_c) begin
            rem_q   <= rem_q - LEN_W'(cnt_q);
            state_q <= ST_CALC;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rcv_q <= '0;
    else if (state_q == ST_CALC) rcv_q <= '0;
    else if (mem_rvalid_i)       rcv_q <= rcv_q + CNT_W'(1);
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);
  assign mem_req_o  = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o   = (state_q == ST_WR);
  assign mem_addr_o = ((state_q == ST_WR) ? dst_o : src_o) + {{PAD{1'b0}}, idx_q};

  AST_ZERO_LEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CALC && rem_q == '0) |=> (done_o && !mem_req_o)) else $error("zero len");  // R1
  AST_CHUNK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD) |-> (cnt_q != '0 && cnt_q <= CNT_W'(CHUNK))) else $error("chunk size");  // R2
  AST_ASC_POSTINC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR && last_c && !up_q) |=>
      (src_o == $past(src_o) + {{PAD{1'b0}}, $past(cnt_q)})) else $error("asc step");  // R3
  AST_DESC_PREDEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CALC && up_q && rem_q != '0) |=>
      (dst_o == $past(dst_o) - {{PAD{1'b0}}, cnt_q})) else $error("desc step");  // R4
  AST_CAPTURE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |-> (rcv_q < cnt_q && !mem_we_o)) else $error("capture");  // R6
  AST_DONE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o) else $error("done");  // R8
  AST_IGNORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(up_q)) else $error("restart");  // R9
endmodule

// File: tb/nib_block_mover_tb.sv
module nib_block_mover_tb;
  localparam int AW = 6;
  localparam int LW = 6;
  localparam int NW = 4;
  localparam int CH = 4;
  localparam int MS = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, dir_up = 1'b0;
  logic [AW-1:0] src = '0, dst = '0;
  logic [LW-1:0] len = '0;
  logic busy, done, req, we, rvalid;
  logic [AW-1:0] src_q, dst_q, addr;
  logic [NW-1:0] wdata, rdata;

  logic [NW-1:0] mem [MS];
  logic [NW-1:0] exp_m [MS];
  int rd_cnt, wr_cnt, first_rd;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  nib_block_mover #(.ADDR_W(AW), .LEN_W(LW), .NIB_W(NW), .CHUNK(CH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_up_i(dir_up),
    .src_i(src), .dst_i(dst), .len_i(len), .busy_o(busy), .done_o(done),
    .src_o(src_q), .dst_o(dst_q), .mem_req_o(req), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_rvalid_i(rvalid)
  );

  always @(posedge clk) begin
    rvalid <= req && !we;
    rdata  <= mem[addr];
    if (req) begin
      if (we) begin
        mem[addr] = wdata;
        wr_cnt++;
      end else begin
        rd_cnt++;
        if (wr_cnt == 0) first_rd++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input bit up, input int s, input int d, input int l, input bit poke);
    int rem, n, es, ed, k, kexp, mism;
    logic [NW-1:0] tmp [CH];
    bit busy_ok;
    for (int i = 0; i < MS; i++) begin
      mem[i]   = NW'((i * 7 + s * 3 + l) & 15);
      exp_m[i] = mem[i];
    end
    rd_cnt = 0; wr_cnt = 0; first_rd = 0;
    es = s; ed = d; rem = l; kexp = 2;
    while (rem > 0) begin
      n = (rem < CH) ? rem : CH;
      if (up) begin
        es = (es - n + MS) % MS;
        ed = (ed - n + MS) % MS;
      end
      for (int i = 0; i < n; i++) tmp[i] = exp_m[(es + i) % MS];
      for (int i = 0; i < n; i++) exp_m[(ed + i) % MS] = tmp[i];
      if (!up) begin
        es = (es + n) % MS;
        ed = (ed + n) % MS;
      end
      rem -= n;
      kexp += 2 * n + 2;
    end
    dir_up = up; src = AW'(s); dst = AW'(d); len = LW'(l);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1; busy_ok = 1'b1;
    while (!done && k < 1000) begin
      if (!busy) busy_ok = 1'b0;
      if (poke && k == 3) begin
        start = 1'b1; dir_up = ~up; len = LW'(5); src = AW'(s + 9); dst = AW'(d + 11);
      end else start = 1'b0;
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk(k == kexp, up ? "R7 R4 done cycle" : "R7 R3 done cycle", k, kexp);
    chk(busy_ok && busy, "R8 busy until done", busy, 1);
    chk(int'(src_q) == es, up ? "R4 R5 src final" : "R3 R5 src final", src_q, es);
    chk(int'(dst_q) == ed, up ? "R4 R5 dst final" : "R3 R5 dst final", dst_q, ed);
    if (poke) chk(int'(src_q) == es, "R9 start while busy ignored", src_q, es);
    @(negedge clk);
    chk(!busy && !done, "R8 single done pulse", {busy, done}, 0);
    mism = 0;
    for (int i = 0; i < MS; i++) if (mem[i] !== exp_m[i]) mism++;
    chk(mism == 0, "R6 memory image", mism, 0);
    chk(rd_cnt == l && wr_cnt == l, "R2 read/write counts", rd_cnt * 100 + wr_cnt, l * 101);
    n = (l < CH) ? l : CH;
    chk(first_rd == n, l == 0 ? "R1 no access" : "R2 first burst", first_rd, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int offs [6];
    int srcs [3];
    int lens [16];
    offs = '{1, 3, -1, -3, 30, 0};
    srcs = '{0, 5, 61};
    for (int i = 0; i < 14; i++) lens[i] = i;
    lens[14] = 40; lens[15] = 63;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req, "R8 reset idle", {busy, done, req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int u = 0; u < 2; u++)
      for (int a = 0; a < 3; a++)
        for (int o = 0; o < 6; o++)
          for (int li = 0; li < 16; li++)
            run(u[0], srcs[a], (srcs[a] + offs[o] + MS) % MS, lens[li], (li % 3) == 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule